// File: doc/BRIEF.md
# MDIO Command Controller

This block performs one clause-22 management transaction at a time towards an external PHY. The whole transaction lives in a single 32-bit control word. Software writes the target PHY number, the register number, the direction and, for a write, the 16-bit payload. In the same write it sets the enable and busy flags.

The controller then generates the management clock and shifts the serial frame out. On a read it releases the data line for the turnaround and collects the reply. It clears the busy flag on the last clock fall. Software polls the same word until busy reads zero; after a read, the reply sits in the low half.

Requests to PHY numbers at or above the supported count never reach the wire. A rejected read completes at once with all-ones data.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the control word reads 0, `mdc` is low and `mdio_oe` is low.
- R2: Control word layout: bits 15:0 data, bits 20:16 register number, bits 25:21 PHY number, bit 27 direction (1 = read, 0 = write), bit 30 enable, bit 31 busy. Bits 29, 28 and 26 always read 0.
- R3: A write with bit 30 clear stores the fields but leaves busy at 0 and produces no `mdc` activity.
- R4: A write with bits 31 and 30 set and a valid PHY number sets busy. While busy is 1, further writes to the control word are ignored.
- R5: A write frame on the line is: 32 ones, start code 01, opcode 01, PHY number and register number (MSB first), turnaround 10, then 16 data bits (MSB first). The PHY samples each bit on the rising edge of `mdc`.
- R6: A read frame carries opcode 10. The master stops driving from the first turnaround bit (bit 46 of 64) to the end of the frame. It samples the 16 reply bits on rising `mdc` edges, MSB first, and places them in bits 15:0 when busy clears.
- R7: Only PHY numbers below NUM_PHYS (default 5) start a frame. A read to any other PHY number produces no frame, clears busy and returns 0xFFFF in bits 15:0. A write to such a PHY number produces no frame and keeps its data field.
- R8: Each `mdc` half period lasts HALF_DIV system clocks. Busy stays high for exactly 1 + 128*HALF_DIV clock cycles, counted from the cycle after the launching write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Value written to the control word |
| reg_rd_data | output | 32 | Current control word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven towards the PHY |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Serial data seen on the line |

## Verification
Each fault has a visible effect at the ports:
- A bit counter or shifter that has gone astray shows up at the end of the frame. The behavioural PHY sees a corrupted header, turnaround or payload, and the control word completes with the wrong reply.
- A divider fault stretches or shrinks the busy window away from 1 + 128*HALF_DIV cycles, so it shows up at the first completion.
- A faulty busy or enable bit shows up within a cycle of the launching write. It either starts clock activity that should not exist or lets a second write overwrite the fields.
- Drive contention during a read turnaround is recorded on the first PHY-owned clock edge.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  // control word field positions
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int REG_LSB   = 16;
  localparam int PHY_LSB   = 21;
  localparam int OP_BIT    = 27;
  localparam int EN_BIT    = 30;
  localparam int BUSY_BIT  = 31;
  // serial frame layout
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic              rd;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = run && (cnt_q == LAST);
  assign rise = term & ~mdc_q;
  assign fall = term & mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdc_q)) |-> ($past(cnt_q) == LAST)); // R8
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift import mdio_cmd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(DATA_IDX);

  logic                 act_q, act_d;
  logic                 rd_q, rd_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {32'hFFFF_FFFF, 2'b01, (cmd.rd ? 2'b10 : 2'b01),
                  cmd.phy, cmd.regad, 2'b10,
                  (cmd.rd ? {DATA_W{1'b0}} : cmd.wdata)};

  always_comb begin
    act_d = act_q;
    rd_d  = rd_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    rx_d  = rx_q;
    if (start) begin
      act_d = 1'b1;
      rd_d  = cmd.rd;
      idx_d = '0;
      sh_d  = frame;
      rx_d  = '0;
    end else if (act_q) begin
      if (rise && rd_q && (idx_q >= DATA_POS))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
      rx_q  <= '0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      rx_q  <= rx_d;
    end
  end

  assign active  = act_q;
  assign done    = act_q & fall & (idx_q == LAST_IDX);
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = act_q & (~rd_q | (idx_q < TA_POS));
  assign rx_data = rx_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q); // R4
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg import mdio_cmd_pkg::*; #(
  parameter int unsigned NUM_PHYS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [31:0]       word
);
  localparam logic [ADDR_W:0] PHY_LIM = (ADDR_W+1)'(NUM_PHYS);

  logic      busy_q, busy_d;
  logic      en_q, en_d;
  logic      start_q, start_d;
  mdio_cmd_t cmd_q, cmd_d;
  logic      phy_ok;
  logic      unused_bits;

  assign unused_bits = ^{wr_data[29:28], wr_data[26]};
  assign phy_ok = ({1'b0, wr_data[PHY_LSB +: ADDR_W]} < PHY_LIM);

  always_comb begin
    busy_d  = busy_q;
    en_d    = en_q;
    cmd_d   = cmd_q;
    start_d = 1'b0;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        if (cmd_q.rd) cmd_d.wdata = rx_data;
      end
    end else if (wr_en) begin
      en_d        = wr_data[EN_BIT];
      cmd_d.phy   = wr_data[PHY_LSB +: ADDR_W];
      cmd_d.regad = wr_data[REG_LSB +: ADDR_W];
      cmd_d.rd    = wr_data[OP_BIT];
      cmd_d.wdata = wr_data[DATA_W-1:0];
      if (wr_data[BUSY_BIT] && wr_data[EN_BIT]) begin
        if (phy_ok) begin
          busy_d  = 1'b1;
          start_d = 1'b1;
        end else if (wr_data[OP_BIT]) begin
          cmd_d.wdata = {DATA_W{1'b1}};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      en_q    <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      en_q    <= en_d;
      start_q <= start_d;
      cmd_q   <= cmd_d;
    end
  end

  assign start = start_q;
  assign cmd   = cmd_q;
  assign word  = {busy_q, en_q, 2'b00, cmd_q.rd, 1'b0, cmd_q.phy, cmd_q.regad, cmd_q.wdata};

  AST_FIELDS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en && !done) |=> $stable(cmd_q)); // R4
  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> en_q); // R3
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl import mdio_cmd_pkg::*; #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned NUM_PHYS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              start, done, active, rise, fall;
  mdio_cmd_t         cmd;
  logic [DATA_W-1:0] rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mdio_cmd_reg #(.NUM_PHYS(NUM_PHYS)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .done(done), .rx_data(rx_data), .start(start), .cmd(cmd), .word(reg_rd_data));

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_int_n), .run(active), .mdc(mdc), .rise(rise), .fall(fall));

  mdio_frame_shift u_shift (
    .clk(clk), .rst_n(rst_int_n), .start(start), .cmd(cmd), .rise(rise), .fall(fall),
    .mdio_i(mdio_i), .active(active), .done(done), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rx_data(rx_data));

  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    mdio_oe |-> reg_rd_data[BUSY_BIT]); // R4
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_rd_data[BUSY_BIT] |-> !mdc); // R3
  AST_BUSY_VALID_PHY: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_rd_data[BUSY_BIT] |-> ({1'b0, reg_rd_data[PHY_LSB +: ADDR_W]} < (ADDR_W+1)'(NUM_PHYS))); // R7
endmodule

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
  localparam int HALF_DIV = 2;
  localparam int BUSY_LEN = 1 + 128 * HALF_DIV;

  logic        clk, rst_n, wr_en;
  logic [31:0] wr_data, rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe, phy_o;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_cmd_ctrl #(.HALF_DIV(HALF_DIV), .NUM_PHYS(5)) u_mdio_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
    .reg_rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_line));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int busy_cycles = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // field layout per R2
  function automatic logic [31:0] mk(input logic busy, input logic en, input logic rd,
                                     input logic [4:0] phy, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {busy, en, 2'b00, rd, 1'b0, phy, ra, d};
  endfunction

  // behavioural PHY
  logic [15:0] phy_mem [0:4][0:31];
  int ph_state = 0, ones = 0, nbits = 0, rcnt = 0;
  int frames = 0, pre_len = 0, contention = 0, mdc_rises = 0;
  logic [11:0] hdr;
  logic [17:0] wbits;
  logic [1:0]  last_op, last_ta;
  logic [4:0]  last_phy, last_reg;
  logic [15:0] rd_val;

  always @(posedge mdc) begin
    mdc_rises++;
    case (ph_state)
      0: if (mdio_line) ones++;
         else begin
           if (ones >= 32) begin pre_len = ones; ph_state = 1; end
           ones = 0;
         end
      1: if (mdio_line) begin ph_state = 2; nbits = 0; end else ph_state = 0;
      2: begin
           hdr = {hdr[10:0], mdio_line};
           nbits++;
           if (nbits == 12) begin
             frames++;
             last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0];
             if (last_op == 2'b10) begin
               ph_state = 4; rcnt = 0;
               rd_val = (last_phy < 5) ? phy_mem[last_phy][last_reg] : 16'hFFFF;
             end else if (last_op == 2'b01) begin
               ph_state = 3; nbits = 0;
             end else ph_state = 0;
           end
         end
      3: begin
           wbits = {wbits[16:0], mdio_line};
           nbits++;
           if (nbits == 18) begin
             last_ta = wbits[17:16];
             if (last_phy < 5) phy_mem[last_phy][last_reg] = wbits[15:0];
             ph_state = 0;
           end
         end
      4: begin
           if (mdio_oe) contention++;
           rcnt++;
           if (rcnt == 18) ph_state = 0;
         end
      default: ph_state = 0;
    endcase
  end

  always @(negedge mdc) begin
    if (ph_state == 4) begin
      if (rcnt == 0) phy_oe = 1'b0;
      else if (rcnt == 1) begin phy_oe = 1'b1; phy_o = 1'b0; end
      else if (rcnt <= 17) begin phy_oe = 1'b1; phy_o = rd_val[17 - rcnt]; end
    end else phy_oe = 1'b0;
  end

  // scoreboard
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic        busy_seen = 1'b0;

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (rd_data[31]) busy_cycles++;
      if (busy_seen && !rd_data[31]) begin
        if (exp_q.size() == 0) chk("R4 unexpected completion", rd_data, 32'h0);
        else chk(req_q.pop_front(), rd_data, exp_q.pop_front());
      end
      busy_seen = rd_data[31];
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic launch(input string req, input logic rd, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [15:0] d, input logic [15:0] expd);
    exp_q.push_back(mk(1'b0, 1'b1, rd, phy, ra, expd));
    req_q.push_back(req);
    busy_cycles = 0;
    wr(mk(1'b1, 1'b1, rd, phy, ra, d));
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int f0, m0;
    for (int p = 0; p < 5; p++)
      for (int r = 0; r < 32; r++) phy_mem[p][r] = 16'(p * 256 + r);
    phy_mem[0][0]  = 16'h1234;
    phy_mem[4][31] = 16'h8001;
    phy_oe = 1'b0; phy_o = 1'b0;
    wr_en = 1'b0; wr_data = '0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 word", rd_data, 32'h0);
    chk("R1 mdc", {31'b0, mdc}, 32'h0);
    chk("R1 oe", {31'b0, mdio_oe}, 32'h0);

    // R3 no enable: fields stored, no activity
    wr(mk(1'b1, 1'b0, 1'b1, 5'd1, 5'd3, 16'h0BAD));
    chk("R3 readback", rd_data, mk(1'b0, 1'b0, 1'b1, 5'd1, 5'd3, 16'h0BAD));
    repeat (20) @(negedge clk);
    chk("R3 no mdc", mdc_rises, 0);
    chk("R3 no frame", frames, 0);

    // R2 reserved bits read zero
    wr(32'h3400_FFFF);
    chk("R2 reserved", rd_data, 32'h0000_FFFF);
    wr(mk(1'b0, 1'b0, 1'b0, 5'd21, 5'd10, 16'h5A5A));
    chk("R2 layout", rd_data, {6'b0, 5'd21, 5'd10, 16'h5A5A});

    // R5 write frame, R8 timing
    launch("R5 write done", 1'b0, 5'd2, 5'd9, 16'hA5C3, 16'hA5C3);
    chk("R4 busy set", {31'b0, rd_data[31]}, 32'h1);
    wait_done();
    chk("R8 busy length", busy_cycles, BUSY_LEN);
    chk("R5 phy mem", phy_mem[2][9], 16'hA5C3);
    chk("R5 opcode", last_op, 2'b01);
    chk("R5 ta", last_ta, 2'b10);
    chk("R5 preamble", pre_len, 32);
    chk("R5 phy/reg", {last_phy, last_reg}, {5'd2, 5'd9});
    chk("R5 frames", frames, 1);

    // R6 reads
    launch("R6 read back", 1'b1, 5'd2, 5'd9, 16'h0000, 16'hA5C3);
    wait_done();
    chk("R6 opcode", last_op, 2'b10);
    chk("R6 released", contention, 0);
    chk("R8 read length", busy_cycles, BUSY_LEN);
    launch("R6 read phy4", 1'b1, 5'd4, 5'd31, 16'h7777, 16'h8001);
    wait_done();
    launch("R6 read phy0", 1'b1, 5'd0, 5'd0, 16'h0000, 16'h1234);
    wait_done();
    chk("R6 released all", contention, 0);

    // R4 writes ignored while busy
    f0 = frames;
    launch("R4 first wins", 1'b0, 5'd1, 5'd5, 16'h0F0F, 16'h0F0F);
    repeat (30) @(negedge clk);
    wr(mk(1'b1, 1'b1, 1'b1, 5'd3, 5'd2, 16'hEEEE));
    chk("R4 fields held", rd_data, mk(1'b1, 1'b1, 1'b0, 5'd1, 5'd5, 16'h0F0F));
    wait_done();
    chk("R4 phy mem", phy_mem[1][5], 16'h0F0F);
    chk("R4 one frame", frames, f0 + 1);
    chk("R4 last op", last_op, 2'b01);

    // R7 out-of-range PHY numbers
    f0 = frames; m0 = mdc_rises;
    wr(mk(1'b1, 1'b1, 1'b1, 5'd5, 5'd0, 16'h0000));
    chk("R7 read reject", rd_data, mk(1'b0, 1'b1, 1'b1, 5'd5, 5'd0, 16'hFFFF));
    wr(mk(1'b1, 1'b1, 1'b0, 5'd31, 5'd7, 16'h1111));
    chk("R7 write reject", rd_data, mk(1'b0, 1'b1, 1'b0, 5'd31, 5'd7, 16'h1111));
    repeat (20) @(negedge clk);
    chk("R7 no frame", frames, f0);
    chk("R7 no mdc", mdc_rises, m0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule